// File: doc/BRIEF.md
# Track Recorder Transport Sequencer

This block is the central sequencer of a small multitrack audio recorder. It receives single-cycle button pulses for record, play, stop, track select and on/off, and turns them into start and stop requests for a capture path and a playback path. Each request is held until the addressed path acknowledges it. The block also keeps the selected track number and exposes its current state as a mode code for a status display, together with a strobe that tells the display to refresh.

After reset the sequencer sits in an initialization state until every attached subsystem reports ready. From idle a user can start a recording or a playback, step the track number, or send the unit back to initialization. While a transfer runs, conflicting buttons are discarded, so the track number cannot change under an active recording or playback.

Top module: `transport_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, mode is 0 (init), track is 0, all four request outputs are low and disp_upd is low.
- R2: In init (mode 0) the machine moves to idle (mode 1) one cycle after the first cycle in which every bit of sub_ready is high; it stays in init otherwise.
- R3: A record press in idle gives mode 2 on the next cycle; cap_start_req is high from that cycle until the cycle after cap_ack is sampled high, then falls while mode stays 2.
- R4: A play press in idle gives mode 4 on the next cycle; pb_start_req is high from that cycle until the cycle after pb_ack is sampled high, then falls while mode stays 4.
- R5: In mode 2, a stop press after the start was acknowledged moves to mode 3, where cap_stop_req is held until cap_ack is sampled high, after which mode returns to 1; a stop press while cap_start_req is still high is ignored.
- R6: In mode 4, a stop press after the start was acknowledged moves to mode 5, where pb_stop_req is held until pb_ack is sampled high, after which mode returns to 1; a stop press while pb_start_req is still high is ignored.
- R7: A track press in idle gives mode 6 for exactly one cycle, then mode 1 with track incremented by one; after N_TRACKS-1 the next value is 0.
- R8: In modes 2 and 4, track, record and play presses are ignored: mode and track stay unchanged by them.
- R9: When several buttons are pressed in the same idle cycle, record wins over play, play over track select, and track select over on/off; stop has no effect in idle.
- R10: An on/off press in idle returns the machine to init (mode 0).
- R11: disp_upd is high for exactly those cycles in which mode or track differs from its value in the previous cycle.
- R12: At most one of the four request outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| btn_rec | input | 1 | Record button pulse |
| btn_play | input | 1 | Play button pulse |
| btn_stop | input | 1 | Stop button pulse |
| btn_track | input | 1 | Track select button pulse |
| btn_power | input | 1 | On/off button pulse |
| sub_ready | input | N_SUB | Ready flags, one per subsystem |
| cap_start_req | output | 1 | Start request to the capture path |
| cap_stop_req | output | 1 | Stop request to the capture path |
| cap_ack | input | 1 | Acknowledge from the capture path |
| pb_start_req | output | 1 | Start request to the playback path |
| pb_stop_req | output | 1 | Stop request to the playback path |
| pb_ack | input | 1 | Acknowledge from the playback path |
| mode | output | 3 | State code: 0 init, 1 idle, 2 record, 3 stop record, 4 play, 5 stop play, 6 change track |
| track | output | $clog2(N_TRACKS) | Selected track number |
| disp_upd | output | 1 | One-cycle display refresh strobe |

## Verification
Every input is sampled at one clock edge, so mode, track and the request outputs show the response one cycle after a button or acknowledge is applied, and disp_upd follows in that same cycle because it is registered from the next-state value. The internal reset release adds two cycles after rst_n rises before the first transition. The bench drives inputs on the falling edge, advances its own model of the requirements for that edge, and compares all outputs one time unit after the next rising edge, so each comparison sees exactly the cycle in which the result is due.

// File: rtl/transport_pkg.sv
package transport_pkg;

  typedef enum logic [2:0] {
    XS_INIT      = 3'd0,
    XS_IDLE      = 3'd1,
    XS_REC       = 3'd2,
    XS_REC_STOP  = 3'd3,
    XS_PLAY      = 3'd4,
    XS_PLAY_STOP = 3'd5,
    XS_TRACK     = 3'd6
  } xport_state_e;

endpackage

// File: rtl/xport_rst_sync.sv
module xport_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_sn  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_sn  <= stage_q;
    end
  end
endmodule

// File: rtl/xport_track.sv
module xport_track #(
  parameter int N_TRACKS = 8,
  localparam int TW = $clog2(N_TRACKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [TW-1:0] trk_q
);
  localparam logic [TW-1:0] LAST = TW'(N_TRACKS - 1);

  logic [TW-1:0] trk_d;

  always_comb begin
    trk_d = trk_q;
    if (inc) trk_d = (trk_q == LAST) ? '0 : trk_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   trk_q <= '0;
    else if (inc) trk_q <= trk_d;
  end
endmodule

// File: rtl/xport_fsm.sv
module xport_fsm
  import transport_pkg::*;
#(
  parameter int N_SUB = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             btn_rec,
  input  logic             btn_play,
  input  logic             btn_stop,
  input  logic             btn_track,
  input  logic             btn_power,
  input  logic [N_SUB-1:0] sub_ready,
  input  logic             cap_ack,
  input  logic             pb_ack,
  output xport_state_e     state_q,
  output xport_state_e     state_d,
  output logic             trk_inc,
  output logic             cap_start_req,
  output logic             cap_stop_req,
  output logic             pb_start_req,
  output logic             pb_stop_req
);
  logic pend_q, pend_d;

  // next-state process
  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    trk_inc = 1'b0;
    unique case (state_q)
      XS_INIT: if (&sub_ready) state_d = XS_IDLE;
      XS_IDLE: begin
        if (btn_rec) begin
          state_d = XS_REC;
          pend_d  = 1'b1;
        end else if (btn_play) begin
          state_d = XS_PLAY;
          pend_d  = 1'b1;
        end else if (btn_track) begin
          state_d = XS_TRACK;
        end else if (btn_power) begin
          state_d = XS_INIT;
        end
      end
      XS_REC: begin
        if (pend_q) begin
          if (cap_ack) pend_d = 1'b0;
        end else if (btn_stop) begin
          state_d = XS_REC_STOP;
        end
      end
      XS_PLAY: begin
        if (pend_q) begin
          if (pb_ack) pend_d = 1'b0;
        end else if (btn_stop) begin
          state_d = XS_PLAY_STOP;
        end
      end
      XS_REC_STOP:  if (cap_ack) state_d = XS_IDLE;
      XS_PLAY_STOP: if (pb_ack)  state_d = XS_IDLE;
      XS_TRACK: begin
        trk_inc = 1'b1;
        state_d = XS_IDLE;
      end
      default: state_d = XS_INIT;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_INIT;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign cap_start_req = (state_q == XS_REC)  && pend_q;
  assign pb_start_req  = (state_q == XS_PLAY) && pend_q;
  assign cap_stop_req  = (state_q == XS_REC_STOP);
  assign pb_stop_req   = (state_q == XS_PLAY_STOP);
endmodule

// File: rtl/transport_ctrl.sv
module transport_ctrl
  import transport_pkg::*;
#(
  parameter int N_SUB    = 3,
  parameter int N_TRACKS = 8,
  localparam int TW = $clog2(N_TRACKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             btn_rec,
  input  logic             btn_play,
  input  logic             btn_stop,
  input  logic             btn_track,
  input  logic             btn_power,
  input  logic [N_SUB-1:0] sub_ready,
  output logic             cap_start_req,
  output logic             cap_stop_req,
  input  logic             cap_ack,
  output logic             pb_start_req,
  output logic             pb_stop_req,
  input  logic             pb_ack,
  output logic [2:0]       mode,
  output logic [TW-1:0]    track,
  output logic             disp_upd
);
  logic         rst_s;
  xport_state_e state_q, state_d;
  logic         trk_inc;
  logic         upd_d;

  xport_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_s)
  );

  xport_fsm #(.N_SUB(N_SUB)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_s),
    .btn_rec       (btn_rec),
    .btn_play      (btn_play),
    .btn_stop      (btn_stop),
    .btn_track     (btn_track),
    .btn_power     (btn_power),
    .sub_ready     (sub_ready),
    .cap_ack       (cap_ack),
    .pb_ack        (pb_ack),
    .state_q       (state_q),
    .state_d       (state_d),
    .trk_inc       (trk_inc),
    .cap_start_req (cap_start_req),
    .cap_stop_req  (cap_stop_req),
    .pb_start_req  (pb_start_req),
    .pb_stop_req   (pb_stop_req)
  );

  xport_track #(.N_TRACKS(N_TRACKS)) u_trk (
    .clk   (clk),
    .rst_n (rst_s),
    .inc   (trk_inc),
    .trk_q (track)
  );

  // display strobe: registered from next mode and track step
  assign upd_d = (state_d != state_q) || trk_inc;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) disp_upd <= 1'b0;
    else        disp_upd <= upd_d;
  end

  assign mode = state_q;
endmodule

// File: rtl/transport_ctrl_chk.sv
module transport_ctrl_chk #(
  parameter int N_SUB    = 3,
  parameter int N_TRACKS = 8,
  localparam int TW = $clog2(N_TRACKS)
) (
  input logic             clk,
  input logic             rst_sn,
  input logic [N_SUB-1:0] sub_ready,
  input logic             cap_start_req,
  input logic             cap_stop_req,
  input logic             cap_ack,
  input logic             pb_start_req,
  input logic             pb_stop_req,
  input logic             pb_ack,
  input logic [2:0]       mode,
  input logic [TW-1:0]    track,
  input logic             disp_upd
);
  logic armed;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  p_one_req_r12: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0({cap_start_req, cap_stop_req, pb_start_req, pb_stop_req}));

  p_init_wait_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (mode == 3'd0 && !(&sub_ready)) |=> (mode == 3'd0));

  p_cap_start_hold_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (cap_start_req && !cap_ack) |=> cap_start_req);

  p_pb_start_hold_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (pb_start_req && !pb_ack) |=> pb_start_req);

  p_cap_stop_hold_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (cap_stop_req && !cap_ack) |=> cap_stop_req);

  p_pb_stop_hold_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (pb_stop_req && !pb_ack) |=> pb_stop_req);

  p_track_wrap_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (mode == 3'd6 && track == TW'(N_TRACKS - 1)) |=> (track == '0));

  p_busy_track_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (mode == 3'd2 || mode == 3'd4) |=> $stable(track));

  p_upd_match_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    armed |-> (disp_upd == ((mode != $past(mode)) || (track != $past(track)))));
endmodule

bind transport_ctrl transport_ctrl_chk #(.N_SUB(N_SUB), .N_TRACKS(N_TRACKS)) u_chk (
  .clk           (clk),
  .rst_sn        (rst_s),
  .sub_ready     (sub_ready),
  .cap_start_req (cap_start_req),
  .cap_stop_req  (cap_stop_req),
  .cap_ack       (cap_ack),
  .pb_start_req  (pb_start_req),
  .pb_stop_req   (pb_stop_req),
  .pb_ack        (pb_ack),
  .mode          (mode),
  .track         (track),
  .disp_upd      (disp_upd)
);

// File: tb/transport_ctrl_tb.sv
`timescale 1ns/1ps
module transport_ctrl_tb;
  localparam int NS = 3;
  localparam int NT = 8;

  logic          clk;
  logic          rst_n;
  logic          b_rec, b_play, b_stop, b_trk, b_pwr;
  logic [NS-1:0] rdy;
  logic          c_ack, p_ack;
  logic          c_sreq, c_preq, p_sreq, p_preq;
  logic [2:0]    mode;
  logic [2:0]    track;
  logic          upd;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model of the requirements
  int m_state, m_trk;
  bit m_pend, m_upd;

  transport_ctrl #(.N_SUB(NS), .N_TRACKS(NT)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .btn_rec(b_rec), .btn_play(b_play), .btn_stop(b_stop),
    .btn_track(b_trk), .btn_power(b_pwr), .sub_ready(rdy),
    .cap_start_req(c_sreq), .cap_stop_req(c_preq), .cap_ack(c_ack),
    .pb_start_req(p_sreq), .pb_stop_req(p_preq), .pb_ack(p_ack),
    .mode(mode), .track(track), .disp_upd(upd)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit e_cs(); return m_state == 2 && m_pend;  endfunction
  function automatic bit e_ps(); return m_state == 4 && m_pend;  endfunction
  function automatic bit e_cp(); return m_state == 3;            endfunction
  function automatic bit e_pp(); return m_state == 5;            endfunction

  function automatic string mode_tag(input int st);
    case (st)
      0: return "R2";
      1: return "R9";
      2, 3: return "R5";
      4, 5: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic void model_step(input bit r, p, s, t, w, all_rdy, ca, pa);
    int ns = m_state;
    int nt = m_trk;
    bit np = m_pend;
    case (m_state)
      0: if (all_rdy) ns = 1;
      1: begin
        if (r)      begin ns = 2; np = 1; end
        else if (p) begin ns = 4; np = 1; end
        else if (t) ns = 6;
        else if (w) ns = 0;
      end
      2: begin if (m_pend) begin if (ca) np = 0; end else if (s) ns = 3; end
      4: begin if (m_pend) begin if (pa) np = 0; end else if (s) ns = 5; end
      3: if (ca) ns = 1;
      5: if (pa) ns = 1;
      default: begin nt = (m_trk + 1) % NT; ns = 1; end
    endcase
    m_upd   = (ns != m_state) || (nt != m_trk);
    m_state = ns;
    m_trk   = nt;
    m_pend  = np;
  endfunction

  // ackpol: 0 never, 1 always, 2 random; ack only while a request is expected
  task automatic step(input bit r, p, s, t, w, input bit all_rdy, input int ackpol);
    bit ca, pa, go;
    int old_state, old_trk;
    @(negedge clk);
    go = (ackpol == 1) || (ackpol == 2 && ($urandom % 3 == 0));
    ca = go && (e_cs() || e_cp());
    pa = go && (e_ps() || e_pp());
    b_rec = r; b_play = p; b_stop = s; b_trk = t; b_pwr = w;
    c_ack = ca; p_ack = pa;
    rdy = all_rdy ? '1 : NS'($urandom % 7);
    old_state = m_state;
    old_trk   = m_trk;
    model_step(r, p, s, t, w, all_rdy, ca, pa);
    @(posedge clk);
    #1;
    chk(int'(mode) == m_state, mode_tag(old_state), int'(mode), m_state);
    chk(int'(track) == m_trk, "R7", int'(track), m_trk);
    if (old_state == 2 || old_state == 4)
      chk(int'(track) == old_trk, "R8", int'(track), old_trk);
    chk(c_sreq == e_cs(), "R3", c_sreq, e_cs());
    chk(p_sreq == e_ps(), "R4", p_sreq, e_ps());
    chk(c_preq == e_cp(), "R5", c_preq, e_cp());
    chk(p_preq == e_pp(), "R6", p_preq, e_pp());
    chk(upd == m_upd, "R11", upd, m_upd);
    chk($countones({c_sreq, c_preq, p_sreq, p_preq}) <= 1, "R12",
        $countones({c_sreq, c_preq, p_sreq, p_preq}), 1);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    {b_rec, b_play, b_stop, b_trk, b_pwr, c_ack, p_ack} = '0;
    rdy = '0;
    m_state = 0; m_trk = 0; m_pend = 0; m_upd = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(mode == 3'd0, "R1", mode, 0);
    chk(track == 3'd0, "R1", track, 0);
    chk({c_sreq, c_preq, p_sreq, p_preq} == 4'b0, "R1",
        {c_sreq, c_preq, p_sreq, p_preq}, 0);
    chk(upd == 1'b0, "R1", upd, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R2: stay in init while a ready bit is low
    repeat (4) step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    chk(mode == 3'd1, "R2", mode, 1);

    // R9: record wins; R5: early stop ignored; R8: busy presses ignored
    step(1, 1, 0, 1, 1, 1, 0);
    chk(mode == 3'd2, "R9", mode, 2);
    step(0, 0, 1, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 1, 0, 1, 0);
    step(0, 1, 0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0, 1, 0);
    step(0, 0, 1, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1, 1);
    chk(mode == 3'd1, "R5", mode, 1);

    // R4, R6: play flow with early stop
    step(0, 1, 1, 1, 0, 1, 0);
    step(0, 0, 1, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1, 1);
    step(0, 0, 1, 1, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1, 1);
    chk(mode == 3'd1, "R6", mode, 1);

    // R7: eight track steps wrap back to zero
    for (int i = 0; i < NT; i++) begin
      step(0, 0, 0, 1, 0, 1, 0);
      step(0, 0, 0, 0, 0, 1, 0);
    end
    chk(track == 3'd0, "R7", track, 0);

    // R10: on/off in idle returns to init; stop in idle does nothing (R9)
    step(0, 0, 1, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1, 1, 0);
    chk(mode == 3'd0, "R10", mode, 0);

    // random traffic
    for (int i = 0; i < 5000; i++) begin
      step(($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 5) == 0,
           ($urandom % 6) == 0, ($urandom % 24) == 0, ($urandom % 4) != 0, 2);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule